// File: doc/BRIEF.md
# Bit-Reversed FFT Address Generator

This block produces the memory addresses that an FFT-style reordering pass needs. A start pulse loads a buffer size of 2^N entries, a base value and a placement choice, and clears an internal index. Each step request then emits one address and advances the index by one. The address comes from the index with its low N bits mirrored, so bit i moves to bit N-1-i. For an 8-entry buffer the visited offsets are 0, 4, 2, 6, 1, 5, 3, 7. When the last offset has been emitted the generator flags completion and goes idle until the next start.

There are two ways to place the buffer in the address space. In aligned placement the buffer sits on a multiple of 2^N, and the address is the upper part of the base with the mirrored index filling the low N bits. In offset placement the buffer may sit anywhere, and the address is the base plus the mirrored index. N can be changed at run time from 1 up to a parameter maximum (10 by default). A configuration error flag reports a start with an unusable setting.

Top module: `bitrev_agu`

## Requirements
- R1: After reset, addr_o is 0 and addr_valid_o, done_o and cfg_err_o are all 0.
- R2: A start with a valid setting clears the index, so the first step after it emits index 0, whose mirrored offset is 0.
- R3: The mirrored offset places index bit i at bit N-1-i. All bits at and above N are zero. With N=3 the offsets run 0,4,2,6,1,5,3,7.
- R4: N is taken from log2_size_i at start and is held for the whole sequence. The accepted values are 1 to MAX_N, and the sequence has exactly 2^N steps.
- R5: With place_i=0 (aligned), addr_o equals base_i with its low N bits replaced by the mirrored offset. The low N bits of the base are ignored.
- R6: With place_i=1 (offset), addr_o equals base_i plus the mirrored offset, modulo 2^ADDR_W.
- R7: addr_o and addr_valid_o change on the clock edge that accepts a step. The address is visible one cycle after the step request, and addr_valid_o is high for exactly that one cycle per accepted step.
- R8: done_o is high for one cycle, in the same cycle as the address of index 2^N-1. After that, steps are ignored: addr_valid_o stays 0 and addr_o holds its value until the next start.
- R9: cfg_err_o is updated on every start and then held. It is 1 if N is outside 1..MAX_N, or if place_i=0 and the low N bits of base_i are nonzero. An out-of-range N leaves the generator idle, so steps are ignored. A nonzero low base in aligned placement still runs.
- R10: A start wins over a step in the same cycle (no address is emitted). A start in the middle of a sequence restarts it at index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the setting and clear the index |
| step_i | input | 1 | Emit the next address |
| log2_size_i | input | NW | N, the log2 of the buffer size |
| base_i | input | ADDR_W | Upper part (aligned) or base (offset) |
| place_i | input | 1 | 0 = aligned, 1 = base plus offset |
| addr_o | output | ADDR_W | Registered address |
| addr_valid_o | output | 1 | addr_o updated this cycle |
| done_o | output | 1 | Last address of the sequence |
| cfg_err_o | output | 1 | Setting of the last start is unusable |

## Verification
Some properties are checked by assertions on every cycle:
- the index stays below 2^N;
- a start clears the index;
- done only appears together with a valid address and lasts one cycle;
- a valid address always follows a step;
- aligned addresses keep the upper base bits.

The exact mirrored order, offset arithmetic with carry and wrap, and error decoding are shown only by the bench scenarios. The same holds for ignoring steps once a sequence is finished or the setting is invalid, and for restarting mid-sequence. These scenarios compare every emitted address with a model of the requirements.

// File: rtl/bitrev_agu_pkg.sv
package bitrev_agu_pkg;
  typedef enum logic {
    PLACE_ALIGNED = 1'b0,
    PLACE_OFFSET  = 1'b1
  } place_e;
endpackage

// File: rtl/bitrev_mirror.sv
module bitrev_mirror #(
  parameter int MAX_N = 10,
  parameter int NW    = $clog2(MAX_N + 1)
) (
  input  logic [MAX_N-1:0] idx_i,
  input  logic [NW-1:0]    n_i,
  output logic [MAX_N-1:0] rev_o
);
  logic [MAX_N-1:0] masked;
  logic [MAX_N-1:0] full_rev;
  logic [NW-1:0]    shr;

  // mirror over MAX_N bits, then slide down so bit i lands at N-1-i
  for (genvar g = 0; g < MAX_N; g++) begin : g_bit
    assign masked[g]             = (NW'(g) < n_i) ? idx_i[g] : 1'b0;
    assign full_rev[MAX_N-1-g]   = masked[g];
  end

  assign shr   = NW'(MAX_N) - n_i;
  assign rev_o = full_rev >> shr;
endmodule

// File: rtl/bitrev_counter.sv
module bitrev_counter #(
  parameter int MAX_N = 10,
  parameter int NW    = $clog2(MAX_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cfg_ok_i,
  input  logic             step_i,
  input  logic [NW-1:0]    n_i,
  output logic [MAX_N-1:0] idx_o,
  output logic             fire_o,
  output logic             last_o
);
  logic [MAX_N-1:0] cnt_q;
  logic             active_q;
  logic [MAX_N:0]   one_sh;
  logic [MAX_N-1:0] lim;

  always_comb begin
    one_sh = (MAX_N + 1)'(1) << n_i;
    lim    = one_sh[MAX_N-1:0] - MAX_N'(1);
  end

  assign fire_o = step_i && active_q && !start_i;
  assign last_o = (cnt_q == lim);
  assign idx_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      cnt_q    <= '0;
      active_q <= cfg_ok_i;
    end else if (fire_o) begin
      cnt_q <= cnt_q + MAX_N'(1);
      if (last_o) active_q <= 1'b0;
    end
  end

  AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cnt_q == '0)); // R10
  AST_IDX_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> (cnt_q <= lim)); // R4
endmodule

// File: rtl/bitrev_place.sv
module bitrev_place
  import bitrev_agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MAX_N  = 10,
  parameter int NW     = $clog2(MAX_N + 1)
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [MAX_N-1:0]  rev_i,
  input  logic [NW-1:0]     n_i,
  input  place_e            place_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] low_mask;
  logic [ADDR_W-1:0] rev_w;

  assign low_mask = (ADDR_W'(1) << n_i) - ADDR_W'(1);
  assign rev_w    = ADDR_W'(rev_i);

  always_comb begin
    if (place_i == PLACE_ALIGNED) addr_o = (base_i & ~low_mask) | rev_w;
    else                          addr_o = base_i + rev_w;
  end
endmodule

// File: rtl/bitrev_agu.sv
module bitrev_agu
  import bitrev_agu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int MAX_N  = 10,
  parameter int NW     = $clog2(MAX_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              step_i,
  input  logic [NW-1:0]     log2_size_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic              place_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_valid_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  logic [NW-1:0]     n_q;
  logic [ADDR_W-1:0] base_q;
  place_e            place_q;
  logic              cfg_ok, low_nz;
  logic [ADDR_W-1:0] in_mask;
  logic [MAX_N-1:0]  idx, rev;
  logic              fire, last;
  logic [ADDR_W-1:0] addr_d;
  logic [ADDR_W-1:0] addr_q;
  logic              valid_q, done_q, err_q;

  assign cfg_ok  = (log2_size_i != '0) && (log2_size_i <= NW'(MAX_N));
  assign in_mask = (ADDR_W'(1) << log2_size_i) - ADDR_W'(1);
  assign low_nz  = |(base_i & in_mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_q     <= NW'(1);
      base_q  <= '0;
      place_q <= PLACE_ALIGNED;
      err_q   <= 1'b0;
    end else if (start_i) begin
      err_q <= !cfg_ok || (place_i == PLACE_ALIGNED && low_nz);
      if (cfg_ok) begin
        n_q     <= log2_size_i;
        base_q  <= base_i;
        place_q <= place_e'(place_i);
      end
    end
  end

  bitrev_counter #(.MAX_N(MAX_N), .NW(NW)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .cfg_ok_i(cfg_ok),
    .step_i  (step_i),
    .n_i     (n_q),
    .idx_o   (idx),
    .fire_o  (fire),
    .last_o  (last)
  );

  bitrev_mirror #(.MAX_N(MAX_N), .NW(NW)) u_mirror (
    .idx_i(idx),
    .n_i  (n_q),
    .rev_o(rev)
  );

  bitrev_place #(.ADDR_W(ADDR_W), .MAX_N(MAX_N), .NW(NW)) u_place (
    .base_i (base_q),
    .rev_i  (rev),
    .n_i    (n_q),
    .place_i(place_q),
    .addr_o (addr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= fire;
      done_q  <= fire && last;
      if (fire) addr_q <= addr_d;
    end
  end

  assign addr_o       = addr_q;
  assign addr_valid_o = valid_q;
  assign done_o       = done_q;
  assign cfg_err_o    = err_q;

  logic [ADDR_W-1:0] hi_mask_q;
  assign hi_mask_q = ~((ADDR_W'(1) << n_q) - ADDR_W'(1));

  AST_DONE_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> addr_valid_o); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_VALID_AFTER_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_valid_o |-> $past(step_i) && !$past(start_i)); // R7
  AST_ALIGNED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_valid_o && place_q == PLACE_ALIGNED)
      |-> ((addr_o & hi_mask_q) == (base_q & hi_mask_q))); // R5
endmodule

// File: tb/bitrev_agu_test.sv
module bitrev_agu_test;
  localparam int ADDR_W = 16;
  localparam int MAX_N  = 10;
  localparam int NW     = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0, step = 1'b0, place = 1'b0;
  logic [NW-1:0]     lsz = '0;
  logic [ADDR_W-1:0] base = '0;
  logic [ADDR_W-1:0] addr;
  logic              vld, done, err;

  int total = 0, bad = 0;
  int cur_n;
  logic [ADDR_W-1:0] cur_base;
  logic cur_place;

  always #10 clk = ~clk;

  bitrev_agu #(.ADDR_W(ADDR_W), .MAX_N(MAX_N), .NW(NW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .step_i(step),
    .log2_size_i(lsz), .base_i(base), .place_i(place),
    .addr_o(addr), .addr_valid_o(vld), .done_o(done), .cfg_err_o(err)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int rev_b(input int idx, input int n);
    int r = 0;
    for (int i = 0; i < n; i++) if (idx[i]) r |= (1 << (n - 1 - i));
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] exp_addr(input int idx);
    logic [ADDR_W-1:0] r = ADDR_W'(rev_b(idx, cur_n));
    logic [ADDR_W-1:0] m = ADDR_W'((1 << cur_n) - 1);
    if (!cur_place) return (cur_base & ~m) | r;
    return cur_base + r;
  endfunction

  task automatic do_start(input int n, input logic [ADDR_W-1:0] b, input logic p,
                          input logic step_too);
    logic exp_err;
    @(negedge clk);
    start = 1'b1; step = step_too; lsz = NW'(n); base = b; place = p;
    @(negedge clk);
    start = 1'b0; step = 1'b0;
    exp_err = (n < 1 || n > MAX_N) || (!p && ((b & ADDR_W'((1 << n) - 1)) != 0));
    chk(err == exp_err, "R9 cfg_err", int'(err), int'(exp_err));
    if (step_too) chk(vld == 1'b0, "R10 start beats step", int'(vld), 0);
    if (n >= 1 && n <= MAX_N) begin
      cur_n = n; cur_base = b; cur_place = p;
    end
  endtask

  task automatic do_step(input int idx, input int gaps);
    logic [ADDR_W-1:0] e = exp_addr(idx);
    logic last = (idx == (1 << cur_n) - 1);
    for (int g = 0; g < gaps; g++) begin
      @(negedge clk);
      chk(vld == 1'b0, "R7 no valid without step", int'(vld), 0);
    end
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk(vld == 1'b1, "R7 valid after step", int'(vld), 1);
    if (!cur_place) chk(addr == e, "R5 aligned address", int'(addr), int'(e));
    else            chk(addr == e, "R6 offset address", int'(addr), int'(e));
    chk(done == last, "R8 done on last", int'(done), int'(last));
  endtask

  task automatic ignored_step(input string req);
    logic [ADDR_W-1:0] held = addr;
    step = 1'b1;
    @(negedge clk);
    step = 1'b0;
    chk(vld == 1'b0 && done == 1'b0, req, int'(vld), 0);
    chk(addr == held, req, int'(addr), int'(held));
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R1
    chk(addr == '0 && vld == 0 && done == 0 && err == 0, "R1 reset state",
        {addr, vld, done, err}, 0);
    rst_n = 1'b1;

    // R3 / R2: N=3 aligned gives 0,4,2,6,1,5,3,7
    do_start(3, 16'h1200, 1'b0, 1'b0);
    begin
      int ord[8] = '{0, 4, 2, 6, 1, 5, 3, 7};
      for (int i = 0; i < 8; i++) begin
        do_step(i, 0);
        chk(addr[2:0] == 3'(ord[i]), "R3 mirrored order", int'(addr[2:0]), ord[i]);
      end
    end
    ignored_step("R8 step after done ignored");

    // R5/R9 aligned with nonzero low base bits
    do_start(3, 16'h1235, 1'b0, 1'b0);
    for (int i = 0; i < 8; i++) do_step(i, 0);

    // R9 invalid N values leave the generator idle
    do_start(0, 16'h0000, 1'b1, 1'b0);
    ignored_step("R9 N=0 idle");
    do_start(11, 16'h0000, 1'b1, 1'b0);
    ignored_step("R9 N=11 idle");

    // R4 extremes: N=1 and N=MAX_N with offset wrap (R6)
    do_start(1, 16'h0040, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) do_step(i, 0);
    do_start(MAX_N, 16'hFF00, 1'b1, 1'b0);
    for (int i = 0; i < (1 << MAX_N); i++) do_step(i, 0);
    ignored_step("R4 sequence length 2^N");

    // R10 restart mid-sequence with a step in the start cycle
    do_start(4, 16'h3000, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) do_step(i, 0);
    do_start(4, 16'h3000, 1'b1, 1'b1);
    do_step(0, 0); // R2 restart at index 0
    for (int i = 1; i < 16; i++) do_step(i, 0);

    // random sequences
    for (int s = 0; s < 30; s++) begin
      int n = 1 + ($urandom % 6);
      logic p = 1'($urandom % 2);
      logic [ADDR_W-1:0] b = ADDR_W'($urandom);
      if (!p && ($urandom % 2)) b &= ~ADDR_W'((1 << n) - 1);
      do_start(n, b, p, 1'b0);
      for (int i = 0; i < (1 << n); i++) do_step(i, $urandom % 3);
      ignored_step("R8 idle after random run");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule